// File: doc/BRIEF.md
# Flash Block Protection Register Unit

This unit keeps two eight-bit permission masks for a flash array divided into eight 2 KB blocks. One mask allows read and execute access. The other allows program and erase. Each bit covers one block. Software reaches the masks through a small register port. A write can only clear a permission bit. Nothing on the write path can set one again.

Cleared bits are temporary at first. A one-cycle commit strobe merges the live masks into a retained copy, and that copy survives every reset. A power-on reset reloads the live masks from the retained copy, so a power cycle undoes uncommitted clears but never undoes committed ones. The retained copy starts fully open, with all ones.

The unit also judges each flash byte address on a separate input. It reports at once whether that address may be read and whether it may be programmed. Addresses beyond the protected range are denied both kinds of access.

Top module: `flash_guard_top`

## Requirements
- R1: Register offset 0x130 holds the read/execute mask and offset 0x134 holds the program/erase mask. Each appears on `rd_data[7:0]` with bit n covering block n. The value for `rd_addr` shows on `rd_data` one clock after the address is presented. Any other offset reads 0.
- R2: `rd_data[31:8]` always reads 0. Data written to bits 31:8 has no effect.
- R3: A write to either mask can only clear bits: the new mask is the old mask AND `wr_data[7:0]`. A 1 in the write data never sets a bit that is 0.
- R4: A write to any offset other than 0x130 or 0x134 changes neither mask.
- R5: Before any commit, the first power-on reset loads both masks with all ones.
- R6: While `por_n` is low, both live masks are loaded from the retained copy. Clears that were never committed are lost.
- R7: A `commit` pulse sets the retained copy to (retained AND live), using the live values from before any write in the same cycle. A retained bit that is 0 never returns to 1.
- R8: While `rst_n` is low, the live masks keep their values, `rd_data` is 0, and both writes and commits are ignored. Writes and commits are also ignored while `por_n` is low.
- R9: For `chk_addr` below 16384, the block number is `chk_addr[13:11]`. `rd_ok` equals that block's read/execute bit and `pg_ok` equals its program/erase bit, with no clock delay.
- R10: For `chk_addr` of 16384 or more, `rd_ok` and `pg_ok` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary reset, active low, synchronous; leaves the masks alone |
| por_n | input | 1 | Power-on reset, active low, synchronous; reloads the masks from the retained copy |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Registered read data |
| commit | input | 1 | One-cycle strobe that merges the live masks into the retained copy |
| chk_addr | input | 15 | Flash byte address to judge |
| rd_ok | output | 1 | Read/execute allowed at `chk_addr` |
| pg_ok | output | 1 | Program/erase allowed at `chk_addr` |

## Verification
The bench writes all ones over cleared bits. A design that treated the register as plain read/write would set those bits again.

A commit and a clearing write are issued in the same cycle. A design that merged the post-write value into the retained copy would make that clear permanent too early.

Power-on resets are issued both with and without a prior commit. A design that reloaded a constant would reopen committed blocks, and one that ignored the reload would keep uncommitted clears.

Address sweeps cover every block edge and the region above 16 KB. These catch a wrong block slice or missing out-of-range denial. Pulses of the ordinary reset expose a design that cleared or reloaded the masks on the wrong reset.

// File: rtl/fg_pkg.sv
`timescale 1ns/1ps
package fg_pkg;
    localparam int NBLK     = 8;
    localparam int BLK_LOG2 = 11;
    localparam int SEL_W    = $clog2(NBLK);
    localparam int REG_AW   = 12;
    localparam int DATA_W   = 32;
    localparam int FLASH_AW = 15;
    localparam int PROT_LIMIT = NBLK << BLK_LOG2;

    localparam logic [REG_AW-1:0] OFS_RDX = 12'h130;
    localparam logic [REG_AW-1:0] OFS_PGM = 12'h134;

    typedef struct packed {
        logic [NBLK-1:0] rdx;
        logic [NBLK-1:0] pgm;
    } mask_pair_t;

    localparam mask_pair_t FACTORY_MASKS = '{rdx: {NBLK{1'b1}}, pgm: {NBLK{1'b1}}};
endpackage

// File: rtl/fg_store.sv
`timescale 1ns/1ps
module fg_store
    import fg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_n,
    input  logic       commit,
    input  mask_pair_t live,
    output mask_pair_t kept
);
    // Retained flops: no reset, factory image as power-up content.
    mask_pair_t kept_d;
    mask_pair_t kept_q = FACTORY_MASKS;

    always_comb begin
        kept_d = kept_q;
        if (commit && por_n && rst_n) begin
            kept_d.rdx = kept_q.rdx & live.rdx;
            kept_d.pgm = kept_q.pgm & live.pgm;
        end
    end

    always_ff @(posedge clk) begin
        kept_q <= kept_d;
    end

    assign kept = kept_q;

    // R7
    kept_never_rises_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_n |=> ((kept_q.rdx & ~$past(kept_q.rdx)) == '0 &&
                   (kept_q.pgm & ~$past(kept_q.pgm)) == '0));

    // R7
    kept_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
        !commit |=> $stable(kept_q));
endmodule

// File: rtl/fg_regfile.sv
`timescale 1ns/1ps
module fg_regfile
    import fg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    input  mask_pair_t        kept,
    output mask_pair_t        live,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        mask_pair_t        live;
        logic [DATA_W-1:0] rd;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!por_n) begin
            st_d.live = kept;
            st_d.rd   = '0;
        end else if (!rst_n) begin
            st_d.rd   = '0;
        end else begin
            if (wr_en && wr_addr == OFS_RDX)
                st_d.live.rdx = st_q.live.rdx & wr_data[NBLK-1:0];
            if (wr_en && wr_addr == OFS_PGM)
                st_d.live.pgm = st_q.live.pgm & wr_data[NBLK-1:0];
            st_d.rd = '0;
            if (rd_addr == OFS_RDX)
                st_d.rd[NBLK-1:0] = st_q.live.rdx;
            else if (rd_addr == OFS_PGM)
                st_d.rd[NBLK-1:0] = st_q.live.pgm;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign live    = st_q.live;
    assign rd_data = st_q.rd;

    // R6
    por_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_n |=> (live == $past(kept)));

    // R3
    clear_only_chk: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> ((live.rdx & ~$past(live.rdx)) == '0 &&
                   (live.pgm & ~$past(live.pgm)) == '0));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_n |-> (rd_data[DATA_W-1:NBLK] == '0));

    // R8
    warm_reset_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> $stable(live));
endmodule

// File: rtl/fg_access.sv
`timescale 1ns/1ps
module fg_access
    import fg_pkg::*;
(
    input  logic [FLASH_AW-1:0] chk_addr,
    input  mask_pair_t          live,
    output logic                rd_ok,
    output logic                pg_ok
);
    logic            in_range;
    logic [NBLK-1:0] blk_sel;

    assign in_range = (int'(chk_addr) < PROT_LIMIT);

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign blk_sel[b] = in_range &&
                            (chk_addr[BLK_LOG2 +: SEL_W] == SEL_W'(b));
    end

    assign rd_ok = |(blk_sel & live.rdx);
    assign pg_ok = |(blk_sel & live.pgm);
endmodule

// File: rtl/flash_guard_top.sv
`timescale 1ns/1ps
module flash_guard_top
    import fg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [REG_AW-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                commit,
    input  logic [FLASH_AW-1:0] chk_addr,
    output logic                rd_ok,
    output logic                pg_ok
);
    mask_pair_t live;
    mask_pair_t kept;

    fg_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .por_n  (por_n),
        .commit (commit),
        .live   (live),
        .kept   (kept)
    );

    fg_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .por_n   (por_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .kept    (kept),
        .live    (live),
        .rd_data (rd_data)
    );

    fg_access u_acc (
        .chk_addr (chk_addr),
        .live     (live),
        .rd_ok    (rd_ok),
        .pg_ok    (pg_ok)
    );

    // R10
    out_of_range_deny_chk: assert property (@(posedge clk) disable iff (!por_n)
        (int'(chk_addr) >= PROT_LIMIT) |-> (!rd_ok && !pg_ok));
endmodule

// File: tb/sim_flash_guard_top.sv
`timescale 1ns/1ps
module sim_flash_guard_top;
    import fg_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                por_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [REG_AW-1:0]   wr_addr = '0;
    logic [DATA_W-1:0]   wr_data = '0;
    logic [REG_AW-1:0]   rd_addr = '0;
    logic [DATA_W-1:0]   rd_data;
    logic                commit = 1'b0;
    logic [FLASH_AW-1:0] chk_addr = '0;
    logic                rd_ok, pg_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_rdx, m_pgm, k_rdx, k_pgm;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    flash_guard_top u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .commit(commit), .chk_addr(chk_addr),
        .rd_ok(rd_ok), .pg_ok(pg_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lf_next();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic do_write(input logic [REG_AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
        if (por_n && rst_n) begin
            if (a == 12'h130) m_rdx = m_rdx & d[7:0];
            if (a == 12'h134) m_pgm = m_pgm & d[7:0];
        end
    endtask

    task automatic do_commit();
        commit = 1'b1;
        step();
        commit = 1'b0;
        if (por_n && rst_n) begin
            k_rdx = k_rdx & m_rdx;
            k_pgm = k_pgm & m_pgm;
        end
    endtask

    task automatic do_por();
        por_n = 1'b0;
        step();
        por_n = 1'b1;
        m_rdx = k_rdx;
        m_pgm = k_pgm;
    endtask

    task automatic read_chk(input logic [REG_AW-1:0] a, input string req);
        logic [31:0] exp;
        rd_addr = a;
        step();
        exp = (a == 12'h130) ? {24'h0, m_rdx} :
              (a == 12'h134) ? {24'h0, m_pgm} : 32'h0;
        chk(req, rd_data, exp);
    endtask

    task automatic read_all(input string req);
        read_chk(12'h130, {req, " R1 rdx"});
        read_chk(12'h134, {req, " R1 pgm"});
        read_chk(12'h138, {req, " R1 other"});
        read_chk(12'h000, {req, " R1 zero"});
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < (1 << FLASH_AW); a += 256) begin
            logic er, ep;
            chk_addr = FLASH_AW'(a);
            #0.5;
            if (a >= 16384) begin
                er = 1'b0; ep = 1'b0;
            end else begin
                er = m_rdx[a >> 11];
                ep = m_pgm[a >> 11];
            end
            chk({req, (a >= 16384) ? " R10 rd" : " R9 rd"}, {31'h0, rd_ok}, {31'h0, er});
            chk({req, (a >= 16384) ? " R10 pg" : " R9 pg"}, {31'h0, pg_ok}, {31'h0, ep});
        end
        for (int b = 0; b < 8; b++) begin
            chk_addr = FLASH_AW'((b << 11) + 2047);
            #0.5;
            chk({req, " R9 block top"}, {30'h0, rd_ok, pg_ok}, {30'h0, m_rdx[b], m_pgm[b]});
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        m_rdx = 8'hFF; m_pgm = 8'hFF; k_rdx = 8'hFF; k_pgm = 8'hFF;
        rd_addr = 12'h130;
        repeat (3) @(negedge clk);
        // R8: read data held at zero in reset
        chk("R8 rd_data in reset", rd_data, 32'h0);
        por_n = 1'b1;
        step();
        chk("R8 rd_data warm reset", rd_data, 32'h0);
        rst_n = 1'b1;

        // R5 factory state
        read_all("R5 factory");
        sweep("R5 open");

        // R3 / R2 clear-only and reserved bits
        do_write(12'h130, 32'hFFFF_FFA5);
        read_all("R3 clear");
        do_write(12'h130, 32'h0000_00FF);
        read_all("R3 no set");
        do_write(12'h134, 32'h5A5A_5A0F);
        read_all("R2 upper ignored");
        // R4 other offsets
        do_write(12'h138, 32'h0);
        do_write(12'h000, 32'h0);
        do_write(12'h131, 32'h0);
        read_all("R4 other offset");
        sweep("R9 partial");

        // R8 warm reset holds masks, blocks writes and commits
        rst_n = 1'b0;
        do_write(12'h130, 32'h0);
        do_commit();
        chk("R8 rd_data cleared", rd_data, 32'h0);
        rst_n = 1'b1;
        read_all("R8 masks kept");

        // R6 uncommitted clears lost
        do_por();
        read_all("R6 reload open");

        // R7 commit then further clear then power-on
        do_write(12'h130, 32'h3C);
        do_commit();
        do_write(12'h130, 32'h0C);
        do_write(12'h134, 32'h00);
        do_por();
        read_all("R7 committed kept");
        sweep("R7 access");

        // R7 commit together with a write: pre-write values retained
        wr_en = 1'b1; wr_addr = 12'h134; wr_data = 32'hF0; commit = 1'b1;
        step();
        wr_en = 1'b0; commit = 1'b0;
        k_rdx = k_rdx & m_rdx; k_pgm = k_pgm & m_pgm;
        m_pgm = m_pgm & 8'hF0;
        read_all("R7 same cycle live");
        do_por();
        read_all("R7 same cycle kept");

        // R8 write during power-on ignored
        por_n = 1'b0;
        do_write(12'h130, 32'h0);
        por_n = 1'b1;
        m_rdx = k_rdx; m_pgm = k_pgm;
        read_all("R8 write in por");

        // pseudo-random mix
        for (int it = 0; it < 40; it++) begin
            logic [REG_AW-1:0] a;
            lf_next();
            case (lf[1:0])
                2'd0: a = 12'h130;
                2'd1: a = 12'h134;
                2'd2: a = 12'h138;
                default: a = 12'h12C;
            endcase
            do_write(a, ~(32'h1 << lf[6:4]) & {lf, lf});
            lf_next();
            if (lf[2]) do_commit();
            if (lf[5]) do_por();
            read_all("R6 R7 mix");
            if (it % 8 == 0) sweep("R9 mix");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule